// File: doc/BRIEF.md
# Fuse Bank Command Controller

The block sits between a simple register port and the timing sequencer of a one-time-programmable fuse array. It keeps a 128-bit bank data store, seen by software as two 64-bit words. It also keeps two command registers, one for reads and one for programming. Each command register holds a bank number, a target select and a go bit. The target select picks one of two places: the permanent fuse array, which is reached through a start/done handshake with an external sequencer, or a volatile soft-blow shadow held inside the block.

A read copies the chosen bank into the data store. A program ORs the data store into the chosen bank. Shadow programming is refused for any bank whose lockdown input is set. Array operations depend on a programming-voltage status input: an array program needs the voltage present, and an array read needs it absent. An operation whose precondition fails ends at once with an error flag and no sequencer activity. When reset is released, the block fetches the default bank from the array, so the data store starts with that bank's contents.

Top module: `fusebank_ctrl`

## Requirements
- R1: After reset the command registers read zero, apart from the voltage bit. The first sequencer operation is an array read of bank RESET_BANK (default 6, fuse bits 895 to 768), and its result ends up in the data store.
- R2: Register offsets: 0 is data store bits 63:0, 1 is bits 127:64, 2 is the read command, 3 is the program command. In both command registers the bank sits in bits 10:4, go in bit 12, the read-only voltage status in bit 14, the target select in bit 15 (1 means array, 0 means shadow) and the read-only error flag in bit 0.
- R3: A shadow read clears its go bit on the second clock edge after the write that set it, and loads the data store with that shadow bank.
- R4: An array read with the voltage absent issues exactly one sequencer start with seq_write low and the bank number. It loads seq_rdata into the store on seq_done and clears go on that same edge.
- R5: An array read with the voltage present issues no sequencer start, leaves the store unchanged, clears go and sets the error flag. Any accepted go bit clears the error flag.
- R6: An array program with the voltage present issues one sequencer start with seq_write high and the data store on seq_wdata, and clears go on seq_done.
- R7: An array program with the voltage absent issues no sequencer start and sets the error flag.
- R8: A shadow program ORs the data store into the addressed shadow bank. No shadow bit ever returns to zero.
- R9: A shadow program to a bank whose lock_bank bit is set leaves that bank unchanged and sets the error flag.
- R10: A shadow read or program of a bank number at or above NUM_BANKS sets the error flag and changes neither the store nor any shadow bank.
- R11: A write to a command register while its own go bit is set is ignored, including the bank and select fields.
- R12: While an operation is pending, writes to the data store and go requests on either command register are ignored. The two go bits are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| prog_volt | input | 1 | Programming-voltage status |
| lock_bank | input | NUM_BANKS | Per-bank shadow lockdown |
| seq_start | output | 1 | One-cycle sequencer start pulse |
| seq_write | output | 1 | Operation type: 1 program, 0 read |
| seq_bank | output | 7 | Bank number for the sequencer |
| seq_wdata | output | 128 | Fuses to blow (the data store) |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_rdata | input | 128 | Bank read from the array |

## Verification
The bench uses the default of eight banks with RESET_BANK 6, and a sequencer model with a three-cycle latency. Eight banks keep every bank within reach of a full sweep of shadow reads, shadow programs and array reads. They also put bank numbers 8 and 127 just past and far past the end of the range. Locking two banks lets the sweep cover both outcomes of lockdown, and the latency leaves a window in which to write while an array read is pending.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int WORD_W = 64;
  localparam int BANK_W = 128;
  localparam int ADDR_W = 7;

  localparam int BIT_ERR  = 0;
  localparam int BANK_LSB = 4;
  localparam int BIT_GO   = 12;
  localparam int BIT_VOLT = 14;
  localparam int BIT_SEL  = 15;

  localparam logic [1:0] OFS_DAT_LO = 2'd0;
  localparam logic [1:0] OFS_DAT_HI = 2'd1;
  localparam logic [1:0] OFS_RCMD   = 2'd2;
  localparam logic [1:0] OFS_PROG   = 2'd3;

  typedef enum logic [2:0] {
    ST_RESET, ST_BOOT, ST_BOOT_WAIT, ST_IDLE, ST_ARR_WAIT
  } fsm_st_e;

  typedef struct packed {
    logic              sel;
    logic              go;
    logic              err;
    logic [ADDR_W-1:0] bank;
  } cmd_reg_t;

  function automatic logic [WORD_W-1:0] pack_cmd(cmd_reg_t c, logic volt);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_ERR] = c.err;
    w[BANK_LSB +: ADDR_W] = c.bank;
    w[BIT_GO] = c.go;
    w[BIT_VOLT] = volt;
    w[BIT_SEL] = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/fbc_cmd_reg.sv
module fbc_cmd_reg
  import fbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_l,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_bank,
  input  logic              accept_go,
  input  logic              fin,
  input  logic              fail,
  output cmd_reg_t          q
);
  cmd_reg_t d;
  logic     en;

  always_comb begin
    d = q;
    if (wr_en && !q.go) begin
      d.sel  = wr_sel;
      d.bank = wr_bank;
      if (wr_go && accept_go) begin
        d.go  = 1'b1;
        d.err = 1'b0;
      end
    end
    if (fin) begin
      d.go  = 1'b0;
      d.err = fail;
    end
  end

  assign en = wr_en | fin;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fbc_shadow.sv
module fbc_shadow
  import fbc_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                        clk,
  input  logic                        rst_l,
  input  logic [ADDR_W-1:0]           rd_idx,
  output logic [BANK_W-1:0]           rd_data,
  output logic                        rd_ok,
  input  logic [ADDR_W-1:0]           wr_idx,
  input  logic                        wr_en,
  input  logic [BANK_W-1:0]           wr_data,
  input  logic [NUM_BANKS-1:0]        lock,
  output logic                        wr_ok,
  output logic [NUM_BANKS*BANK_W-1:0] flat
);
  logic [BANK_W-1:0] bank_q [NUM_BANKS];
  logic              wr_locked;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = wr_en && (wr_idx == ADDR_W'(g)) && !lock[g];
    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l)   bank_q[g] <= '0;
      else if (hit) bank_q[g] <= bank_q[g] | wr_data;
    end
    assign flat[g*BANK_W +: BANK_W] = bank_q[g];
  end

  always_comb begin
    rd_data   = '0;
    wr_locked = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (rd_idx == ADDR_W'(i)) rd_data   = bank_q[i];
      if (wr_idx == ADDR_W'(i)) wr_locked = lock[i];
    end
  end

  assign rd_ok = (32'(rd_idx) < NUM_BANKS);
  assign wr_ok = (32'(wr_idx) < NUM_BANKS) && !wr_locked;
endmodule

// File: rtl/fbc_store.sv
module fbc_store
  import fbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_l,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ld_en,
  input  logic [BANK_W-1:0] ld_data,
  output logic [BANK_W-1:0] q
);
  logic [BANK_W-1:0] d;
  logic              en;

  always_comb begin
    d = q;
    if (wr_lo) d[WORD_W-1:0]      = wr_data;
    if (wr_hi) d[BANK_W-1:WORD_W] = wr_data;
    if (ld_en) d = ld_data;
  end

  assign en = wr_lo | wr_hi | ld_en;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fbc_seqctl.sv
module fbc_seqctl
  import fbc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_BANK = 7'd6
) (
  input  logic              clk,
  input  logic              rst_l,
  input  cmd_reg_t          rcmd,
  input  cmd_reg_t          pcmd,
  input  logic              volt,
  input  logic              sh_rd_ok,
  input  logic              sh_wr_ok,
  input  logic              seq_done,
  output logic              seq_start,
  output logic              seq_write,
  output logic [ADDR_W-1:0] seq_bank,
  output logic              ld_arr,
  output logic              ld_sh,
  output logic              sh_wr,
  output logic              rfin,
  output logic              rfail,
  output logic              pfin,
  output logic              pfail,
  output logic              idle_ok
);
  fsm_st_e st_q, st_d;
  logic    booting;

  assign booting   = (st_q == ST_BOOT) || (st_q == ST_BOOT_WAIT);
  assign seq_bank  = booting ? RESET_BANK : (rcmd.go ? rcmd.bank : pcmd.bank);
  assign seq_write = !booting && !rcmd.go && pcmd.go;
  assign idle_ok   = (st_q == ST_IDLE) && !rcmd.go && !pcmd.go;

  always_comb begin
    st_d      = st_q;
    seq_start = 1'b0;
    ld_arr    = 1'b0;
    ld_sh     = 1'b0;
    sh_wr     = 1'b0;
    rfin      = 1'b0;
    rfail     = 1'b0;
    pfin      = 1'b0;
    pfail     = 1'b0;
    unique case (st_q)
      ST_RESET: st_d = ST_BOOT;
      ST_BOOT: begin
        seq_start = 1'b1;
        st_d      = ST_BOOT_WAIT;
      end
      ST_BOOT_WAIT: begin
        if (seq_done) begin
          ld_arr = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (rcmd.go) begin
          if (rcmd.sel) begin
            if (volt) begin
              rfin  = 1'b1;
              rfail = 1'b1;
            end else begin
              seq_start = 1'b1;
              st_d      = ST_ARR_WAIT;
            end
          end else begin
            rfin  = 1'b1;
            rfail = !sh_rd_ok;
            ld_sh = sh_rd_ok;
          end
        end else if (pcmd.go) begin
          if (pcmd.sel) begin
            if (!volt) begin
              pfin  = 1'b1;
              pfail = 1'b1;
            end else begin
              seq_start = 1'b1;
              st_d      = ST_ARR_WAIT;
            end
          end else begin
            pfin  = 1'b1;
            pfail = !sh_wr_ok;
            sh_wr = sh_wr_ok;
          end
        end
      end
      ST_ARR_WAIT: begin
        if (seq_done) begin
          st_d = ST_IDLE;
          if (rcmd.go) begin
            ld_arr = 1'b1;
            rfin   = 1'b1;
          end else begin
            pfin = 1'b1;
          end
        end
      end
      default: st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) st_q <= ST_RESET;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/fusebank_ctrl.sv
module fusebank_ctrl
  import fbc_pkg::*;
#(
  parameter int                NUM_BANKS  = 8,
  parameter logic [ADDR_W-1:0] RESET_BANK = 7'd6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic                 prog_volt,
  input  logic [NUM_BANKS-1:0] lock_bank,
  output logic                 seq_start,
  output logic                 seq_write,
  output logic [ADDR_W-1:0]    seq_bank,
  output logic [BANK_W-1:0]    seq_wdata,
  input  logic                 seq_done,
  input  logic [BANK_W-1:0]    seq_rdata
);
  localparam int FLAT_W = NUM_BANKS * BANK_W;

  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  cmd_reg_t          rcmd, pcmd;
  logic              idle_ok, ld_arr, ld_sh, sh_wr;
  logic              rfin, rfail, pfin, pfail;
  logic              sh_rd_ok, sh_wr_ok;
  logic [BANK_W-1:0] store_q, sh_rd_data, ld_data;
  logic [FLAT_W-1:0] shadow_flat;
  logic              wr_rcmd, wr_prog, wr_lo, wr_hi;

  assign wr_rcmd = reg_wr && (reg_addr == OFS_RCMD);
  assign wr_prog = reg_wr && (reg_addr == OFS_PROG);
  assign wr_lo   = reg_wr && (reg_addr == OFS_DAT_LO) && idle_ok;
  assign wr_hi   = reg_wr && (reg_addr == OFS_DAT_HI) && idle_ok;

  fbc_cmd_reg u_rcmd (
    .clk(clk), .rst_l(rst_l), .wr_en(wr_rcmd),
    .wr_sel(reg_wdata[BIT_SEL]), .wr_go(reg_wdata[BIT_GO]),
    .wr_bank(reg_wdata[BANK_LSB +: ADDR_W]), .accept_go(idle_ok),
    .fin(rfin), .fail(rfail), .q(rcmd)
  );

  fbc_cmd_reg u_pcmd (
    .clk(clk), .rst_l(rst_l), .wr_en(wr_prog),
    .wr_sel(reg_wdata[BIT_SEL]), .wr_go(reg_wdata[BIT_GO]),
    .wr_bank(reg_wdata[BANK_LSB +: ADDR_W]), .accept_go(idle_ok),
    .fin(pfin), .fail(pfail), .q(pcmd)
  );

  fbc_shadow #(.NUM_BANKS(NUM_BANKS)) u_shadow (
    .clk(clk), .rst_l(rst_l),
    .rd_idx(rcmd.bank), .rd_data(sh_rd_data), .rd_ok(sh_rd_ok),
    .wr_idx(pcmd.bank), .wr_en(sh_wr), .wr_data(store_q),
    .lock(lock_bank), .wr_ok(sh_wr_ok), .flat(shadow_flat)
  );

  fbc_seqctl #(.RESET_BANK(RESET_BANK)) u_seq (
    .clk(clk), .rst_l(rst_l), .rcmd(rcmd), .pcmd(pcmd), .volt(prog_volt),
    .sh_rd_ok(sh_rd_ok), .sh_wr_ok(sh_wr_ok), .seq_done(seq_done),
    .seq_start(seq_start), .seq_write(seq_write), .seq_bank(seq_bank),
    .ld_arr(ld_arr), .ld_sh(ld_sh), .sh_wr(sh_wr),
    .rfin(rfin), .rfail(rfail), .pfin(pfin), .pfail(pfail), .idle_ok(idle_ok)
  );

  assign ld_data = ld_arr ? seq_rdata : sh_rd_data;

  fbc_store u_store (
    .clk(clk), .rst_l(rst_l), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(reg_wdata), .ld_en(ld_arr | ld_sh), .ld_data(ld_data),
    .q(store_q)
  );

  assign seq_wdata = store_q;

  always_comb begin
    unique case (reg_addr)
      OFS_DAT_LO: reg_rdata = store_q[WORD_W-1:0];
      OFS_DAT_HI: reg_rdata = store_q[BANK_W-1:WORD_W];
      OFS_RCMD:   reg_rdata = pack_cmd(rcmd, prog_volt);
      default:    reg_rdata = pack_cmd(pcmd, prog_volt);
    endcase
  end
endmodule

// File: rtl/fbc_chk.sv
module fbc_chk
  import fbc_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input logic                        clk,
  input logic                        rst_l,
  input logic                        seq_start,
  input logic                        seq_write,
  input logic                        seq_done,
  input logic                        prog_volt,
  input logic                        r_go,
  input logic                        p_go,
  input logic [ADDR_W-1:0]           r_bank,
  input logic [ADDR_W-1:0]           p_bank,
  input logic [NUM_BANKS-1:0]        lock_bank,
  input logic [NUM_BANKS*BANK_W-1:0] shadow_flat
);
  logic outst_q, booted_q;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      outst_q  <= 1'b0;
      booted_q <= 1'b0;
    end else begin
      if (seq_start)     outst_q <= 1'b1;
      else if (seq_done) outst_q <= 1'b0;
      if (seq_start)     booted_q <= 1'b1;
    end
  end

  // R4
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_l)
    seq_start |-> !outst_q);

  // R7
  prog_needs_volt_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (seq_start && seq_write) |-> prog_volt);

  // R5
  read_needs_novolt_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (seq_start && !seq_write && booted_q) |-> !prog_volt);

  // R11
  rbank_hold_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (r_go && $past(r_go)) |-> $stable(r_bank));

  // R11
  pbank_hold_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (p_go && $past(p_go)) |-> $stable(p_bank));

  // R12
  go_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_l)
    !(r_go && p_go));

  // R8
  shadow_monotone_chk: assert property (@(posedge clk) disable iff (!rst_l)
    ($past(shadow_flat) & ~shadow_flat) == '0);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_lock
    // R9
    locked_bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_l)
      lock_bank[g] |=> $stable(shadow_flat[g*BANK_W +: BANK_W]));
  end
endmodule

bind fusebank_ctrl fbc_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_l(rst_l), .seq_start(seq_start), .seq_write(seq_write),
  .seq_done(seq_done), .prog_volt(prog_volt),
  .r_go(rcmd.go), .p_go(pcmd.go), .r_bank(rcmd.bank), .p_bank(pcmd.bank),
  .lock_bank(lock_bank), .shadow_flat(shadow_flat)
);

// File: tb/fusebank_ctrl_tb.sv
`timescale 1ns/1ps
module fusebank_ctrl_tb;
  localparam int NB  = 8;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic          prog_volt = 1'b0;
  logic [NB-1:0] lock_bank = 8'b0010_1000;
  logic          seq_start, seq_write, seq_done;
  logic [6:0]    seq_bank;
  logic [127:0]  seq_wdata, seq_rdata;

  int n_chk = 0, n_bad = 0, n_start = 0, n_proto = 0;
  logic [127:0] arr [NB];
  logic [127:0] exp_arr [NB];
  logic [127:0] exp_sh [NB];

  always #4 clk = ~clk;

  fusebank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prog_volt(prog_volt),
    .lock_bank(lock_bank), .seq_start(seq_start), .seq_write(seq_write),
    .seq_bank(seq_bank), .seq_wdata(seq_wdata), .seq_done(seq_done),
    .seq_rdata(seq_rdata)
  );

  function automatic logic [127:0] pat(int i);
    logic [31:0] k;
    k = 32'(i);
    return {k * 32'h1111_1111, ~(k * 32'h0123_4567), 32'hC3C3_0000 | k, (k + 32'd1) << 20};
  endfunction

  // sequencer model
  logic       pend = 1'b0, w_q = 1'b0;
  int         cnt = 0;
  logic [6:0] b_q = '0;
  logic [127:0] wd_q = '0;
  initial begin
    seq_done = 1'b0;
    seq_rdata = '0;
    for (int i = 0; i < NB; i++) begin
      arr[i] = pat(i);
      exp_arr[i] = pat(i);
      exp_sh[i] = '0;
    end
  end
  always @(posedge clk) begin
    seq_done <= 1'b0;
    if (seq_start) begin
      if (pend) n_proto++;
      n_start++;
      pend <= 1'b1; cnt <= LAT; w_q <= seq_write; b_q <= seq_bank; wd_q <= seq_wdata;
    end else if (pend) begin
      if (cnt == 0) begin
        pend <= 1'b0;
        seq_done <= 1'b1;
        if (w_q) arr[b_q[2:0]] <= arr[b_q[2:0]] | wd_q;
        else     seq_rdata <= arr[b_q[2:0]];
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [63:0] cw(bit sel, bit go, int bank);
    return (64'(sel) << 15) | (64'(go) << 12) | (64'(bank[6:0]) << 4);
  endfunction

  task automatic wait_clear(input logic [1:0] a, input string tag);
    logic [63:0] v;
    int n;
    n = 0;
    rd(a, v);
    while (v[12] && n < 50) begin
      @(negedge clk);
      rd(a, v);
      n++;
    end
    if (v[12]) chk(1'b0, {tag, " go never cleared"}, 128'(v), 0);
  endtask

  task automatic run(input logic [1:0] a, input logic [63:0] d, input string tag);
    wr(a, d);
    wait_clear(a, tag);
  endtask

  task automatic rd_store(output logic [127:0] s);
    logic [63:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    s = {hi, lo};
  endtask

  task automatic set_store(input logic [127:0] s);
    wr(2'd0, s[63:0]);
    wr(2'd1, s[127:64]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [127:0] s, pat2;
    logic [63:0] v;
    int st0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1 boot read of bank 6
    rd_store(s);
    chk(s == pat(6), "R1 store after boot", s, pat(6));
    chk(n_start == 1, "R1 single boot start", 128'(n_start), 1);
    rd(2'd2, v); chk(v == 0, "R1 read cmd reset", 128'(v), 0);
    rd(2'd3, v); chk(v == 0, "R1 prog cmd reset", 128'(v), 0);

    // R2 voltage bit and field layout
    prog_volt = 1'b1;
    rd(2'd2, v); chk(v == 64'h4000, "R2 volt bit rcmd", 128'(v), 128'h4000);
    rd(2'd3, v); chk(v == 64'h4000, "R2 volt bit prog", 128'(v), 128'h4000);
    prog_volt = 1'b0;
    wr(2'd3, cw(1, 0, 5));
    rd(2'd3, v); chk(v == 64'h8050, "R2 sel/bank layout", 128'(v), 128'h8050);

    // R3 shadow read timing and content
    wr(2'd2, cw(0, 1, 0));
    rd(2'd2, v); chk(v[12] == 1'b1, "R3 go visible one cycle", 128'(v), 128'h1000);
    @(negedge clk);
    rd(2'd2, v); chk(v[12] == 1'b0, "R3 go cleared second edge", 128'(v), 0);
    rd_store(s); chk(s == 0, "R3 shadow bank0 empty", s, 0);

    // R8/R9 soft program sweep, two passes
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < 2; p++) begin
        pat2 = (p == 0) ? pat(b + 16) : {pat(b + 40)} & 128'h00FF_00FF_0F0F_F0F0_1234_5678_9ABC_DEF0;
        set_store(pat2);
        run(2'd3, cw(0, 1, b), "R8");
        rd(2'd3, v);
        if (lock_bank[b]) chk(v[0] == 1'b1, "R9 locked err", 128'(v), 1);
        else begin
          chk(v[0] == 1'b0, "R8 soft prog ok", 128'(v), 0);
          exp_sh[b] = exp_sh[b] | pat2;
        end
      end
    end
    for (int b = 0; b < NB; b++) begin
      run(2'd2, cw(0, 1, b), "R3");
      rd_store(s);
      chk(s == exp_sh[b], lock_bank[b] ? "R9 locked bank unchanged" : "R8 shadow OR content", s, exp_sh[b]);
    end

    // R4 array read sweep
    for (int b = 0; b < NB; b++) begin
      st0 = n_start;
      run(2'd2, cw(1, 1, b), "R4");
      rd_store(s);
      chk(s == exp_arr[b], "R4 array read data", s, exp_arr[b]);
      chk(n_start == st0 + 1, "R4 one start", 128'(n_start), 128'(st0 + 1));
    end

    // R5 array read with voltage present
    st0 = n_start;
    prog_volt = 1'b1;
    wr(2'd2, cw(1, 1, 2));
    @(negedge clk);
    rd(2'd2, v); chk(v[12] == 1'b0 && v[0] == 1'b1, "R5 immediate err", 128'(v), 128'h4001);
    prog_volt = 1'b0;
    rd_store(s); chk(s == exp_arr[7], "R5 store unchanged", s, exp_arr[7]);
    chk(n_start == st0, "R5 no start", 128'(n_start), 128'(st0));
    run(2'd2, cw(0, 1, 1), "R5");
    rd(2'd2, v); chk(v[0] == 1'b0, "R5 err cleared by new go", 128'(v), 0);

    // R6 array program with voltage
    pat2 = 128'hF000_0000_0000_0000_0000_0000_0000_000F;
    set_store(pat2);
    prog_volt = 1'b1;
    st0 = n_start;
    run(2'd3, cw(1, 1, 2), "R6");
    prog_volt = 1'b0;
    chk(n_start == st0 + 1, "R6 one write start", 128'(n_start), 128'(st0 + 1));
    exp_arr[2] = exp_arr[2] | pat2;
    run(2'd2, cw(1, 1, 2), "R6");
    rd_store(s); chk(s == exp_arr[2], "R6 array ORed", s, exp_arr[2]);

    // R7 array program without voltage
    st0 = n_start;
    set_store('1);
    run(2'd3, cw(1, 1, 4), "R7");
    rd(2'd3, v); chk(v[0] == 1'b1, "R7 err set", 128'(v), 1);
    chk(n_start == st0, "R7 no start", 128'(n_start), 128'(st0));
    run(2'd2, cw(1, 1, 4), "R7");
    rd_store(s); chk(s == exp_arr[4], "R7 array untouched", s, exp_arr[4]);

    // R10 out-of-range banks
    run(2'd2, cw(0, 1, 8), "R10");
    rd(2'd2, v); chk(v[0] == 1'b1, "R10 read bank 8 err", 128'(v), 1);
    rd_store(s); chk(s == exp_arr[4], "R10 store unchanged", s, exp_arr[4]);
    run(2'd3, cw(0, 1, 127), "R10");
    rd(2'd3, v); chk(v[0] == 1'b1, "R10 prog bank 127 err", 128'(v), 1);

    // R11/R12 writes during a pending array read
    wr(2'd2, cw(1, 1, 1));
    wr(2'd2, cw(0, 0, 4));
    rd(2'd2, v); chk(v[10:4] == 7'd1 && v[15], "R11 bank/sel held", 128'(v), 128'h9010);
    wr(2'd0, 64'hDEAD_BEEF_0000_1111);
    wr(2'd3, cw(0, 1, 0));
    rd(2'd3, v); chk(v[12] == 1'b0, "R12 prog go refused", 128'(v), 0);
    wait_clear(2'd2, "R12");
    rd_store(s); chk(s == exp_arr[1], "R12 store write ignored", s, exp_arr[1]);
    run(2'd2, cw(0, 1, 0), "R12");
    rd_store(s); chk(s == exp_sh[0], "R12 shadow0 untouched", s, exp_sh[0]);
    chk(n_proto == 0, "R4 no overlapping starts", 128'(n_proto), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule